// File: doc/BRIEF.md
# Serial Link Startup Handshake Sequencer

This block runs the bring-up of a one-way high-speed serial link that has a few slow return wires. It drives the receiver's two status bits and tells the transmitter which fill frame to send. It also decides when the host may start pushing user data. The transmitter first sends fill type 0. Once the receiver holds frame lock it raises status bit 1. That turns its frequency detector off and moves the transmitter to fill type 1. A run of fill-type-1 frames then raises status bit 0, which opens the data path.

The sequencer is clocked once per received frame. The decoded type of that frame is presented on `rxFrameType` in every cycle. A build option covers a system in which the receiver reset is held inactive and the lock wire is absent. With that option the receiver counts as always enabled and the transmitter lock input has no effect.

Top module: `link_bringup_seq`

## Requirements
- R1: While `rst` is high, and right after it is released, the outputs are `stat0`=0, `stat1`=0, `fillSel`=0, `dataEn`=0, `readyForData`=0 and `freqDetEn`=1.
- R2: With `ALWAYS_EN`=0, `rxEnable` follows `txLocked` and stays low while `txLocked` is low. During that time the status bits stay 00 whatever `frameLocked` and `rxFrameType` do.
- R3: Suppose the receiver is enabled and has been out of its initial state for one clock. Then a high `frameLocked` raises `stat1` at the next clock edge. While `stat1`=1, `freqDetEn`=0 and `fillSel`=1 (fill type 1 is selected). While `stat1`=0, `fillSel`=0 (fill type 0 is selected) and `freqDetEn`=1.
- R4: `dataEn` always equals `stat0`, and `stat0` is never high unless `stat1` is high.
- R5: Frame type codes are 0 for fill type 0, 1 for fill type 1, 2 for data and 3 for invalid. While `stat1`=1 and frame lock holds, `stat0` rises at the clock edge that samples the `FILL1_COUNT`-th consecutive code-1 frame. The default count is 2. Any other code resets the run.
- R6: `readyForData` rises one clock after `dataEn` rises. It falls on the same clock edge as `dataEn`.
- R7: If `frameLocked` is low at a clock edge while `stat1`=1, both status bits clear at that edge. Data is disabled and fill type 0 is selected again.
- R8: With `ALWAYS_EN`=0, a low `txLocked` drives `rxEnable` low in the same cycle, with no clock edge needed. At the next edge the sequencer returns to the R1 output state, and it holds there until `txLocked` returns.
- R9: Data frames (code 2) seen before `stat0` is high do not advance the sequence toward `stat0`.
- R10: With `ALWAYS_EN`=1, `rxEnable` is always 1 and `txLocked` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per received frame |
| rst | input | 1 | Synchronous active-high reset |
| txLocked | input | 1 | Transmitter clock lock indication |
| frameLocked | input | 1 | Receiver frame lock indication |
| rxFrameType | input | 2 | Decoded type of the frame received this cycle |
| stat0 | output | 1 | Receiver status bit 0 (data allowed) |
| stat1 | output | 1 | Receiver status bit 1 (frame locked) |
| rxEnable | output | 1 | Receiver enable |
| freqDetEn | output | 1 | Receiver frequency detector enable |
| fillSel | output | 1 | Fill frame type for the transmitter (0 or 1) |
| dataEn | output | 1 | Transmitter user-data enable |
| readyForData | output | 1 | Registered ready flag to the host |

## Verification
The assertions check a set of rules on every cycle:
- the status bits are ordered, and `dataEn` matches `stat0`;
- the frequency detector and the fill select track `stat1`;
- a loss of frame lock or transmitter lock clears the status bits at the next edge;
- `stat0` only rises after a fill-type-1 frame;
- the ready flag never outlives `dataEn`.

Other behaviour depends on a history of frames, so only the bench's scenarios can show it. That covers the exact count of consecutive fill-type-1 frames, the reset of that count by data or fill-type-0 frames, and the one-cycle lag of the ready flag. It also covers the always-enabled build ignoring transmitter lock.

// File: rtl/linkseq_pkg.sv
package linkseq_pkg;
  typedef enum logic [1:0] {
    FRM_FILL0 = 2'd0,
    FRM_FILL1 = 2'd1,
    FRM_DATA  = 2'd2,
    FRM_BAD   = 2'd3
  } frame_e;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_HUNT = 2'd1,
    ST_LOCK = 2'd2,
    ST_RUN  = 2'd3
  } seq_e;

  typedef struct packed {
    logic cntInc;
    logic cntClr;
    logic readyNext;
    logic stat1;
    logic stat0;
  } strobe_t;
endpackage

// File: rtl/link_seq_ctrl.sv
module link_seq_ctrl
  import linkseq_pkg::*;
#(
  parameter bit ALWAYS_EN = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       txLocked,
  input  logic       frameLocked,
  input  logic [1:0] rxFrameType,
  input  logic       cntLast,
  output strobe_t    strb,
  output logic       rxEnable
);
  seq_e   state, nextState;
  frame_e frameType;
  logic   linkUp;
  logic   inc, clr;

  assign frameType = frame_e'(rxFrameType);
  assign linkUp    = ALWAYS_EN ? 1'b1 : txLocked;
  assign rxEnable  = linkUp;

  always_comb begin
    nextState = state;
    inc       = 1'b0;
    clr       = 1'b0;
    if (!linkUp) begin
      nextState = ST_OFF;
      clr       = 1'b1;
    end else begin
      unique case (state)
        ST_OFF: begin
          nextState = ST_HUNT;
          clr       = 1'b1;
        end
        ST_HUNT: begin
          clr = 1'b1;
          if (frameLocked) nextState = ST_LOCK;
        end
        ST_LOCK: begin
          if (!frameLocked) begin
            nextState = ST_HUNT;
            clr       = 1'b1;
          end else if (frameType == FRM_FILL1) begin
            if (cntLast) begin
              nextState = ST_RUN;
              clr       = 1'b1;
            end else begin
              inc = 1'b1;
            end
          end else begin
            clr = 1'b1;
          end
        end
        ST_RUN: begin
          clr = 1'b1;
          if (!frameLocked) nextState = ST_HUNT;
        end
        default: nextState = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_OFF;
    else     state <= nextState;
  end

  always_comb begin
    strb.cntInc    = inc;
    strb.cntClr    = clr;
    strb.readyNext = (state == ST_RUN) && (nextState == ST_RUN);
    strb.stat1     = (state == ST_LOCK) || (state == ST_RUN);
    strb.stat0     = (state == ST_RUN);
  end
endmodule

// File: rtl/link_seq_dp.sv
module link_seq_dp
  import linkseq_pkg::*;
#(
  parameter int FILL1_COUNT = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  strobe_t strb,
  output logic    cntLast,
  output logic    stat0,
  output logic    stat1,
  output logic    freqDetEn,
  output logic    fillSel,
  output logic    dataEn,
  output logic    readyForData
);
  localparam int CNT_W = (FILL1_COUNT < 2) ? 1 : $clog2(FILL1_COUNT);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(FILL1_COUNT - 1);

  logic [CNT_W-1:0] runCnt;
  logic             readyQ;

  always_ff @(posedge clk) begin
    if (rst || strb.cntClr) runCnt <= '0;
    else if (strb.cntInc)   runCnt <= runCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) readyQ <= 1'b0;
    else     readyQ <= strb.readyNext;
  end

  assign cntLast      = (runCnt == LAST_VAL);
  assign stat0        = strb.stat0;
  assign stat1        = strb.stat1;
  assign freqDetEn    = ~strb.stat1;
  assign fillSel      = strb.stat1;
  assign dataEn       = strb.stat0;
  assign readyForData = readyQ;
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
  import linkseq_pkg::*;
#(
  parameter int FILL1_COUNT = 2,
  parameter bit ALWAYS_EN   = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       txLocked,
  input  logic       frameLocked,
  input  logic [1:0] rxFrameType,
  output logic       stat0,
  output logic       stat1,
  output logic       rxEnable,
  output logic       freqDetEn,
  output logic       fillSel,
  output logic       dataEn,
  output logic       readyForData
);
  strobe_t strb;
  logic    cntLast;

  link_seq_ctrl #(.ALWAYS_EN(ALWAYS_EN)) u_ctrl (
    .clk(clk), .rst(rst), .txLocked(txLocked), .frameLocked(frameLocked),
    .rxFrameType(rxFrameType), .cntLast(cntLast), .strb(strb), .rxEnable(rxEnable)
  );

  link_seq_dp #(.FILL1_COUNT(FILL1_COUNT)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .cntLast(cntLast),
    .stat0(stat0), .stat1(stat1), .freqDetEn(freqDetEn), .fillSel(fillSel),
    .dataEn(dataEn), .readyForData(readyForData)
  );
endmodule

// File: rtl/link_seq_chk.sv
module link_seq_chk #(
  parameter bit ALWAYS_EN = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic       txLocked,
  input logic       frameLocked,
  input logic [1:0] rxFrameType,
  input logic       stat0,
  input logic       stat1,
  input logic       rxEnable,
  input logic       freqDetEn,
  input logic       fillSel,
  input logic       dataEn,
  input logic       readyForData
);
  AST_STAT_ORDER: assert property (@(posedge clk) disable iff (rst)
    stat0 |-> stat1) else $error("stat0 without stat1"); // R4
  AST_DATA_MATCHES_STAT: assert property (@(posedge clk) disable iff (rst)
    dataEn == stat0) else $error("dataEn differs from stat0"); // R4
  AST_LOCKED_SETTINGS: assert property (@(posedge clk) disable iff (rst)
    stat1 |-> (!freqDetEn && fillSel)) else $error("lock settings wrong"); // R3
  AST_HUNT_SETTINGS: assert property (@(posedge clk) disable iff (rst)
    !stat1 |-> (freqDetEn && !fillSel)) else $error("hunt settings wrong"); // R3
  AST_LOSS_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (stat1 && !frameLocked) |=> (!stat1 && !stat0)) else $error("lock loss kept status"); // R7
  AST_RX_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !rxEnable |=> (!stat1 && !stat0 && !readyForData)) else $error("disabled rx kept status"); // R8
  AST_RX_FOLLOWS_LOCK: assert property (@(posedge clk) disable iff (rst)
    (!ALWAYS_EN && !txLocked) |-> !rxEnable) else $error("rx enabled without tx lock"); // R2
  AST_RX_ALWAYS: assert property (@(posedge clk) disable iff (rst)
    ALWAYS_EN |-> rxEnable) else $error("always-enabled rx went low"); // R10
  AST_STAT0_AFTER_FILL1: assert property (@(posedge clk) disable iff (rst)
    $rose(stat0) |-> ($past(rxFrameType) == 2'd1)) else $error("stat0 rose without fill1"); // R5
  AST_READY_NOT_STALE: assert property (@(posedge clk) disable iff (rst)
    readyForData |-> dataEn) else $error("ready without dataEn"); // R6
endmodule

bind link_bringup_seq link_seq_chk #(.ALWAYS_EN(ALWAYS_EN)) u_chk (.*);

// File: tb/link_bringup_seq_tb.sv
module link_bringup_seq_tb;
  localparam int N = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txLocked = 1'b0;
  logic frameLocked = 1'b0;
  logic [1:0] rxFrameType = 2'd0;

  logic [1:0] s0, s1, rxe, fde, fs, de, rdy;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int mSt[2];
  int mCnt[2];
  bit mRdy[2];

  always #5 clk = ~clk;

  link_bringup_seq #(.FILL1_COUNT(N), .ALWAYS_EN(1'b0)) u_dut (
    .clk(clk), .rst(rst), .txLocked(txLocked), .frameLocked(frameLocked),
    .rxFrameType(rxFrameType), .stat0(s0[0]), .stat1(s1[0]), .rxEnable(rxe[0]),
    .freqDetEn(fde[0]), .fillSel(fs[0]), .dataEn(de[0]), .readyForData(rdy[0])
  );

  link_bringup_seq #(.FILL1_COUNT(N), .ALWAYS_EN(1'b1)) u_dutAlw (
    .clk(clk), .rst(rst), .txLocked(txLocked), .frameLocked(frameLocked),
    .rxFrameType(rxFrameType), .stat0(s0[1]), .stat1(s1[1]), .rxEnable(rxe[1]),
    .freqDetEn(fde[1]), .fillSel(fs[1]), .dataEn(de[1]), .readyForData(rdy[1])
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit upOf(int k);
    return (k == 1) || txLocked;
  endfunction

  task automatic updModel(int k);
    int st, nst, ncnt;
    st = mSt[k];
    nst = st;
    ncnt = 0;
    if (rst) nst = 0;
    else if (!upOf(k)) nst = 0;
    else begin
      case (st)
        0: nst = 1;
        1: if (frameLocked) nst = 2;
        2: begin
          if (!frameLocked) nst = 1;
          else if (rxFrameType == 2'd1) begin
            if (mCnt[k] == N - 1) nst = 3;
            else ncnt = mCnt[k] + 1;
          end
        end
        default: if (!frameLocked) nst = 1;
      endcase
    end
    mRdy[k] = !rst && (st == 3) && (nst == 3);
    mSt[k] = nst;
    mCnt[k] = ncnt;
  endtask

  task automatic compareModel(int k);
    bit e1, e0;
    string rx;
    e1 = (mSt[k] >= 2);
    e0 = (mSt[k] == 3);
    rx = (k == 1) ? "R10" : "R2";
    chk("R3", "stat1", s1[k], e1);
    chk("R5", "stat0", s0[k], e0);
    chk("R3", "fillSel", fs[k], e1);
    chk("R3", "freqDetEn", fde[k], !e1);
    chk("R4", "dataEn", de[k], e0);
    chk("R6", "readyForData", rdy[k], mRdy[k]);
    chk(rx, "rxEnable", rxe[k], upOf(k));
  endtask

  task automatic step();
    @(posedge clk);
    updModel(0);
    updModel(1);
    @(negedge clk);
    #1;
    compareModel(0);
    compareModel(1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    for (int k = 0; k < 2; k++) begin
      mSt[k] = 0; mCnt[k] = 0; mRdy[k] = 1'b0;
    end
    rst = 1'b1;
    for (int i = 0; i < 3; i++) step();
    for (int k = 0; k < 2; k++) begin
      chk("R1", "reset stat0", s0[k], 1'b0);
      chk("R1", "reset stat1", s1[k], 1'b0);
      chk("R1", "reset fillSel", fs[k], 1'b0);
      chk("R1", "reset dataEn", de[k], 1'b0);
      chk("R1", "reset ready", rdy[k], 1'b0);
      chk("R1", "reset freqDetEn", fde[k], 1'b1);
    end

    rst = 1'b0; txLocked = 1'b0; frameLocked = 1'b1; rxFrameType = 2'd1;
    for (int i = 0; i < 4; i++) step();
    chk("R2", "stat1 held without tx lock", s1[0], 1'b0);
    chk("R2", "rxEnable low without tx lock", rxe[0], 1'b0);
    chk("R10", "always-enabled reaches stat0", s0[1], 1'b1);

    txLocked = 1'b1;
    step();
    chk("R3", "stat1 before hunt edge", s1[0], 1'b0);
    step();
    chk("R3", "stat1 after frame lock", s1[0], 1'b1);
    chk("R3", "fill type 1 selected", fs[0], 1'b1);
    chk("R3", "freq detector off", fde[0], 1'b0);

    rxFrameType = 2'd2;
    for (int i = 0; i < 3; i++) step();
    chk("R9", "data frames do not raise stat0", s0[0], 1'b0);
    rxFrameType = 2'd1;
    step();
    chk("R5", "stat0 after one fill1", s0[0], 1'b0);
    step();
    chk("R5", "stat0 after second fill1", s0[0], 1'b1);
    chk("R4", "dataEn with stat0", de[0], 1'b1);
    chk("R6", "ready lags dataEn", rdy[0], 1'b0);
    step();
    chk("R6", "ready one cycle later", rdy[0], 1'b1);

    frameLocked = 1'b0;
    step();
    chk("R7", "stat1 cleared on lock loss", s1[0], 1'b0);
    chk("R7", "stat0 cleared on lock loss", s0[0], 1'b0);
    chk("R7", "fill type 0 again", fs[0], 1'b0);
    chk("R6", "ready falls with dataEn", rdy[0], 1'b0);

    frameLocked = 1'b1; rxFrameType = 2'd1;
    step();
    step();
    rxFrameType = 2'd0;
    step();
    chk("R5", "fill0 breaks the run", s0[0], 1'b0);
    rxFrameType = 2'd1;
    step();
    chk("R5", "one fill1 after break", s0[0], 1'b0);
    step();
    chk("R5", "stat0 after restarted run", s0[0], 1'b1);
    step();
    chk("R6", "ready high again", rdy[0], 1'b1);

    @(negedge clk);
    txLocked = 1'b0;
    #1;
    chk("R8", "rxEnable drops at once", rxe[0], 1'b0);
    chk("R10", "always-enabled ignores tx lock", rxe[1], 1'b1);
    step();
    chk("R8", "stat1 cleared after tx lock loss", s1[0], 1'b0);
    chk("R8", "ready cleared after tx lock loss", rdy[0], 1'b0);
    chk("R10", "always-enabled keeps stat0", s0[1], 1'b1);

    for (int i = 0; i < 4000; i++) begin
      int r;
      rst = (($urandom % 200) == 0);
      txLocked = (($urandom % 100) < 97);
      frameLocked = (($urandom % 100) < 92);
      r = $urandom % 10;
      rxFrameType = (r < 6) ? 2'd1 : (r == 6) ? 2'd0 : (r == 7) ? 2'd2 : 2'd3;
      step();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule